// File: doc/BRIEF.md
# Fully associative cache controller

This block is a small cache that sits between a byte-wide load/store port on the processor side and a slower memory port that moves whole blocks. It has no index field. Any memory block may live in any slot. Every slot's tag is compared with the request at the same time, and a slot only takes part in the comparison when its valid bit is set. A hit completes in the cycle the request is presented. A miss stalls the requester while the controller fetches the whole block. If the victim slot holds modified data, the controller first writes that data back.

Misses fill the lowest-numbered empty slot while one is free. After that they replace the least recently used slot. Recency is kept as one age counter per slot, and hits refresh the order as well as fills. Two compile-time options choose the policies. The first picks write-back (with a dirty bit per slot) or write-through for write hits. The second picks write-allocate or no-write-allocate for write misses. Parameters set the address width, the block size as a power of two, and the slot count.

Top module: `fa_cache`

## Requirements
- R1: The low OFFS_W address bits select the byte within a block of 2^OFFS_W bytes, and the remaining upper bits form the tag. A read returns the byte at that offset.
- R2: After reset every slot is invalid, so the first access to any block misses. With no request pending, cpu_ready and mem_req stay low.
- R3: A read hit, or a write hit in write-back mode, raises cpu_ready with cpu_hit=1 in the same cycle the request is presented, with no memory traffic.
- R4: A miss while a slot is invalid fills the lowest-numbered invalid slot and evicts nothing. After four distinct blocks are loaded into four slots, all four hit.
- R5: A miss with every slot valid replaces the least recently used slot, and hits count as use. With 6-bit addresses, 4-byte blocks and 4 slots, starting cold, the byte addresses 0,2,4,8,20,16,0,2 give miss,hit,miss,miss,miss,miss,miss,hit. The addresses 0,2,2,0,16,20,8,4 give 5 misses.
- R6: In write-back mode a write hit changes only the cache and marks the slot dirty. A dirty block is written to memory exactly once, as a full block (mem_be all ones), when it is evicted and before the refill.
- R7: In write-through mode a write hit updates the cached byte and also issues a one-byte memory write. That write sets mem_be bit i for byte lane i (lane i is mem_wdata[8i+7:8i]) at the request offset. cpu_ready rises when the memory accepts the write.
- R8: With write-allocate, a write miss fetches the block, then completes as a write hit. A later read of that byte hits and returns the written value.
- R9: With no-write-allocate, a write miss writes the byte straight to memory and fetches nothing. A later read of that block still misses.
- R10: mem_req and its address and direction stay stable until mem_ready is seen. mem_addr is the block number, the address shifted right by OFFS_W. A miss keeps cpu_ready low until the refill is done.
- R11: cpu_hit is 0 on completion of any access that missed, including allocate misses that finish through the hit path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_rdata | output | 8 | Load byte, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_hit | output | 1 | Completing access hit without a miss |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = block read |
| mem_addr | output | ADDR_W-OFFS_W | Block number |
| mem_be | output | 2^OFFS_W | Byte-lane write enables |
| mem_wdata | output | 8*2^OFFS_W | Write data, lane i at bits 8i+7:8i |
| mem_ready | input | 1 | Memory transfer done this cycle |
| mem_rdata | input | 8*2^OFFS_W | Block read data, valid with mem_ready |

## Verification
A hit is due in the cycle the request is presented, because cpu_ready and cpu_rdata come combinationally from the tag search. A miss is due only after the eviction and refill handshakes finish, and their length depends on the memory's latency. For that reason the bench polls cpu_ready in the middle of each cycle and counts the cycles it waited: zero is expected for a hit and a nonzero count for a miss or a write-through store. Memory-side effects are checked only after the access has completed, by reading the backing model's transfer counters, last byte enables and contents.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EVICT = 2'd1,
      ST_FILL  = 2'd2,
      ST_WRITE = 2'd3
   } fsm_t;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
   parameter int SLOTS = 4,
   parameter int TAG_W = 4,
   parameter int IDX_W = 2
) (
   input  logic [SLOTS-1:0]            valid,
   input  logic [SLOTS-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]            look_tag,
   output logic [SLOTS-1:0]            hit_vec,
   output logic                        hit_any,
   output logic [IDX_W-1:0]            hit_idx,
   output logic                        free_any,
   output logic [IDX_W-1:0]            free_idx
);
   genvar g;
   generate
      for (g = 0; g < SLOTS; g++) begin : g_cmp
         assign hit_vec[g] = valid[g] && (tags[g] == look_tag);
      end
   endgenerate

   assign hit_any  = |hit_vec;
   assign free_any = ~&valid;

   // descending scan so the lowest numbered slot wins
   always_comb begin
      hit_idx  = '0;
      free_idx = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_idx = IDX_W'(i);
         if (!valid[i])  free_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/fa_lru.sv
module fa_lru #(
   parameter int SLOTS = 4,
   parameter int IDX_W = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        touch,
   input  logic [IDX_W-1:0]            touch_idx,
   output logic [IDX_W-1:0]            lru_idx,
   output logic [SLOTS-1:0][IDX_W-1:0] age_o
);
   logic [SLOTS-1:0][IDX_W-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) age_q[i] <= IDX_W'(i);
      end else if (touch) begin
         for (int i = 0; i < SLOTS; i++) begin
            if (IDX_W'(i) == touch_idx)
               age_q[i] <= '0;
            else if (age_q[i] < age_q[touch_idx])
               age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   always_comb begin
      lru_idx = '0;
      for (int i = 0; i < SLOTS; i++)
         if (age_q[i] == IDX_W'(SLOTS - 1)) lru_idx = IDX_W'(i);
   end

   assign age_o = age_q;
endmodule

// File: rtl/fa_cache.sv
module fa_cache
   import fa_cache_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int OFFS_W      = 2,
   parameter int SLOTS       = 4,
   parameter int WRITE_BACK  = 1,
   parameter int WRITE_ALLOC = 1,
   localparam int TAG_W = ADDR_W - OFFS_W,
   localparam int BLK_B = 1 << OFFS_W,
   localparam int BLK_W = 8 * BLK_B,
   localparam int IDX_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [7:0]        cpu_wdata,
   output logic [7:0]        cpu_rdata,
   output logic              cpu_ready,
   output logic              cpu_hit,
   output logic              mem_req,
   output logic              mem_we,
   output logic [TAG_W-1:0]  mem_addr,
   output logic [BLK_B-1:0]  mem_be,
   output logic [BLK_W-1:0]  mem_wdata,
   input  logic              mem_ready,
   input  logic [BLK_W-1:0]  mem_rdata
);
   generate
      if (OFFS_W < 1 || ADDR_W <= OFFS_W) begin : g_bad_addr
         $error("fa_cache: need 1 <= OFFS_W < ADDR_W");
      end
      if (SLOTS < 2) begin : g_bad_slots
         $error("fa_cache: need at least two slots");
      end
   endgenerate

   fsm_t                        state_q, state_d;
   logic [SLOTS-1:0]            valid_q;
   logic [SLOTS-1:0][TAG_W-1:0] tag_q;
   logic [SLOTS-1:0][BLK_W-1:0] data_q;
   logic [SLOTS-1:0]            dirty_vec;
   logic [IDX_W-1:0]            victim_q;
   logic                        miss_q;

   logic [TAG_W-1:0]  req_tag;
   logic [OFFS_W-1:0] req_off;
   logic [SLOTS-1:0]  hit_vec;
   logic              hit_any, free_any;
   logic [IDX_W-1:0]  hit_idx, free_idx, lru_idx, victim_sel;
   logic [SLOTS-1:0][IDX_W-1:0] lru_age;
   logic idle_req, take_hit, wr_hit, bypass_miss, alloc_miss, fill_done;

   assign req_tag = cpu_addr[ADDR_W-1:OFFS_W];
   assign req_off = cpu_addr[OFFS_W-1:0];

   fa_tag_match #(.SLOTS(SLOTS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
      .valid(valid_q), .tags(tag_q), .look_tag(req_tag),
      .hit_vec(hit_vec), .hit_any(hit_any), .hit_idx(hit_idx),
      .free_any(free_any), .free_idx(free_idx)
   );

   fa_lru #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_lru (
      .clk(clk), .rst_n(rst_n), .touch(take_hit), .touch_idx(hit_idx),
      .lru_idx(lru_idx), .age_o(lru_age)
   );

   assign victim_sel  = free_any ? free_idx : lru_idx;
   assign idle_req    = (state_q == ST_IDLE) && cpu_req;
   assign take_hit    = idle_req && hit_any;
   assign wr_hit      = take_hit && cpu_we;
   assign bypass_miss = idle_req && !hit_any && cpu_we && (WRITE_ALLOC == 0);
   assign alloc_miss  = idle_req && !hit_any && !bypass_miss;
   assign fill_done   = (state_q == ST_FILL) && mem_ready;

   assign cpu_ready = (take_hit && !(cpu_we && (WRITE_BACK == 0)))
                    || ((state_q == ST_WRITE) && mem_ready);
   assign cpu_hit   = cpu_ready && !miss_q;
   assign cpu_rdata = data_q[hit_idx][{req_off, 3'b000} +: 8];

   // write-hit policy variant: dirty tracking exists only for write-back
   generate
      if (WRITE_BACK != 0) begin : g_wb
         logic [SLOTS-1:0] dirty_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dirty_q <= '0;
            else if (fill_done) dirty_q[victim_q] <= 1'b0;
            else if (wr_hit) dirty_q[hit_idx] <= 1'b1;
         end
         assign dirty_vec = dirty_q;
      end else begin : g_wt
         assign dirty_vec = '0;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (wr_hit && (WRITE_BACK == 0)) state_d = ST_WRITE;
            else if (bypass_miss)            state_d = ST_WRITE;
            else if (alloc_miss)             state_d = dirty_vec[victim_sel] ? ST_EVICT : ST_FILL;
         end
         ST_EVICT: if (mem_ready) state_d = ST_FILL;
         ST_FILL:  if (mem_ready) state_d = ST_IDLE;
         ST_WRITE: if (mem_ready) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         victim_q <= '0;
         miss_q   <= 1'b0;
         valid_q  <= '0;
         tag_q    <= '0;
      end else begin
         state_q <= state_d;
         if (alloc_miss) victim_q <= victim_sel;
         if (cpu_ready) miss_q <= 1'b0;
         else if (alloc_miss || bypass_miss) miss_q <= 1'b1;
         if (fill_done) begin
            valid_q[victim_q] <= 1'b1;
            tag_q[victim_q]   <= req_tag;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_done) data_q[victim_q] <= mem_rdata;
      else if (wr_hit) data_q[hit_idx][{req_off, 3'b000} +: 8] <= cpu_wdata;
   end

   assign mem_req   = (state_q != ST_IDLE);
   assign mem_we    = (state_q == ST_EVICT) || (state_q == ST_WRITE);
   assign mem_addr  = (state_q == ST_EVICT) ? tag_q[victim_q] : req_tag;
   assign mem_be    = (state_q == ST_WRITE) ? (BLK_B'(1) << req_off) : '1;
   assign mem_wdata = (state_q == ST_EVICT) ? data_q[victim_q] : {BLK_B{cpu_wdata}};
endmodule

// File: rtl/fa_cache_chk.sv
module fa_cache_chk #(
   parameter int SLOTS = 4,
   parameter int IDX_W = 2,
   parameter int TAG_W = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cpu_req,
   input logic                        cpu_ready,
   input logic                        cpu_hit,
   input logic                        mem_req,
   input logic                        mem_we,
   input logic                        mem_ready,
   input logic [TAG_W-1:0]            mem_addr,
   input logic [SLOTS-1:0]            hit_vec,
   input logic [SLOTS-1:0]            valid_q,
   input logic [SLOTS-1:0][IDX_W-1:0] lru_age
);
   logic [(1<<IDX_W)-1:0] seen;
   always_comb begin
      seen = '0;
      for (int i = 0; i < SLOTS; i++) seen[lru_age[i]] = 1'b1;
   end

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R3
   AST_COLD_START: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (valid_q == '0)); // R2
   AST_READY_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req); // R10
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
   AST_LRU_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      (&seen[SLOTS-1:0])); // R5
   AST_MISS_USED_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && !cpu_hit) |-> (mem_req || $past(mem_req))); // R11
endmodule

bind fa_cache fa_cache_chk #(.SLOTS(SLOTS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
   .cpu_hit(cpu_hit), .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
   .mem_addr(mem_addr), .hit_vec(hit_vec), .valid_q(valid_q), .lru_age(lru_age)
);

// File: tb/sim_fa_cache.sv
`timescale 1ns/1ps

module sim_mem_model #(
   parameter int ADDR_W = 6,
   parameter int OFFS_W = 2,
   parameter int LAT    = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        mem_req,
   input  logic                        mem_we,
   input  logic [ADDR_W-OFFS_W-1:0]    mem_addr,
   input  logic [(1<<OFFS_W)-1:0]      mem_be,
   input  logic [8*(1<<OFFS_W)-1:0]    mem_wdata,
   output logic                        mem_ready,
   output logic [8*(1<<OFFS_W)-1:0]    mem_rdata,
   output int                          n_rd,
   output int                          n_wr,
   output logic [(1<<OFFS_W)-1:0]      last_be
);
   logic [7:0] bytes_q [1<<ADDR_W];
   int cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ready <= 1'b0;
         mem_rdata <= '0;
         cnt <= 0; n_rd <= 0; n_wr <= 0; last_be <= '0;
         for (int a = 0; a < (1<<ADDR_W); a++) bytes_q[a] <= 8'((a * 7 + 3) ^ 8'h5A);
      end else if (mem_ready) begin
         mem_ready <= 1'b0;
      end else if (mem_req) begin
         if (cnt == LAT) begin
            mem_ready <= 1'b1;
            cnt <= 0;
            if (mem_we) begin
               for (int b = 0; b < (1<<OFFS_W); b++)
                  if (mem_be[b]) bytes_q[{mem_addr, OFFS_W'(b)}] <= mem_wdata[8*b +: 8];
               n_wr <= n_wr + 1;
               last_be <= mem_be;
            end else begin
               for (int b = 0; b < (1<<OFFS_W); b++)
                  mem_rdata[8*b +: 8] <= bytes_q[{mem_addr, OFFS_W'(b)}];
               n_rd <= n_rd + 1;
            end
         end else begin
            cnt <= cnt + 1;
         end
      end
   end
endmodule

module sim_fa_cache;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int total = 0;
   int bad = 0;

   // unit 0: write-back + write-allocate, unit 1: write-through + no-write-allocate
   logic       c0_req = 0, c0_we = 0, c1_req = 0, c1_we = 0;
   logic [5:0] c0_addr = 0, c1_addr = 0;
   logic [7:0] c0_wd = 0, c1_wd = 0;
   logic [7:0] c0_rd, c1_rd;
   logic       c0_ready, c0_hit, c1_ready, c1_hit;
   logic       m0_req, m0_we, m0_rdy, m1_req, m1_we, m1_rdy;
   logic [3:0] m0_addr, m1_addr, m0_be, m1_be, m0_lbe, m1_lbe;
   logic [31:0] m0_wd, m1_wd, m0_rd, m1_rd;
   int m0_nrd, m0_nwr, m1_nrd, m1_nwr;

   fa_cache #(.WRITE_BACK(1), .WRITE_ALLOC(1)) u0 (
      .clk(clk), .rst_n(rst_n), .cpu_req(c0_req), .cpu_we(c0_we), .cpu_addr(c0_addr),
      .cpu_wdata(c0_wd), .cpu_rdata(c0_rd), .cpu_ready(c0_ready), .cpu_hit(c0_hit),
      .mem_req(m0_req), .mem_we(m0_we), .mem_addr(m0_addr), .mem_be(m0_be),
      .mem_wdata(m0_wd), .mem_ready(m0_rdy), .mem_rdata(m0_rd));
   sim_mem_model m0 (
      .clk(clk), .rst_n(rst_n), .mem_req(m0_req), .mem_we(m0_we), .mem_addr(m0_addr),
      .mem_be(m0_be), .mem_wdata(m0_wd), .mem_ready(m0_rdy), .mem_rdata(m0_rd),
      .n_rd(m0_nrd), .n_wr(m0_nwr), .last_be(m0_lbe));

   fa_cache #(.WRITE_BACK(0), .WRITE_ALLOC(0)) u1 (
      .clk(clk), .rst_n(rst_n), .cpu_req(c1_req), .cpu_we(c1_we), .cpu_addr(c1_addr),
      .cpu_wdata(c1_wd), .cpu_rdata(c1_rd), .cpu_ready(c1_ready), .cpu_hit(c1_hit),
      .mem_req(m1_req), .mem_we(m1_we), .mem_addr(m1_addr), .mem_be(m1_be),
      .mem_wdata(m1_wd), .mem_ready(m1_rdy), .mem_rdata(m1_rd));
   sim_mem_model m1 (
      .clk(clk), .rst_n(rst_n), .mem_req(m1_req), .mem_we(m1_we), .mem_addr(m1_addr),
      .mem_be(m1_be), .mem_wdata(m1_wd), .mem_ready(m1_rdy), .mem_rdata(m1_rd),
      .n_rd(m1_nrd), .n_wr(m1_nwr), .last_be(m1_lbe));

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7 + 3) ^ 8'h5A);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic acc(input int u, input logic we, input int a, input logic [7:0] wd,
                      output logic [7:0] rd, output logic hit, output int waits);
      @(negedge clk);
      if (u == 0) begin c0_req = 1; c0_we = we; c0_addr = 6'(a); c0_wd = wd; end
      else        begin c1_req = 1; c1_we = we; c1_addr = 6'(a); c1_wd = wd; end
      waits = 0;
      while (1) begin
         #1;
         if ((u == 0) ? c0_ready : c1_ready) break;
         if (waits > 200) begin
            total++; bad++;
            $display("FAIL R10 access timeout actual=%0d expected=<=200", waits);
            break;
         end
         @(negedge clk);
         waits++;
      end
      rd  = (u == 0) ? c0_rd : c1_rd;
      hit = (u == 0) ? c0_hit : c1_hit;
      @(posedge clk);
      #1;
      c0_req = 0; c1_req = 0;
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk); #1;
      chk("R2 idle cpu_ready u0", int'(c0_ready), 0);
      chk("R2 idle mem_req u0", int'(m0_req), 0);
      chk("R2 idle mem_req u1", int'(m1_req), 0);
   endtask

   task automatic t_seq(input int which);
      int seq [8];
      bit eh [8];
      int misses = 0;
      logic [7:0] rd; logic h; int w;
      if (which == 1) begin
         seq = '{0, 2, 4, 8, 20, 16, 0, 2};
         eh  = '{0, 1, 0, 0, 0, 0, 0, 1};
      end else begin
         seq = '{0, 2, 2, 0, 16, 20, 8, 4};
         eh  = '{0, 1, 1, 1, 0, 0, 0, 0};
      end
      do_reset();
      for (int i = 0; i < 8; i++) begin
         acc(0, 0, seq[i], 8'h00, rd, h, w);
         chk($sformatf("R5 seq%0d step%0d hit", which, i), int'(h), int'(eh[i]));
         chk($sformatf("R1 seq%0d step%0d data", which, i), int'(rd), int'(pat(seq[i])));
         if (!h) misses++;
      end
      chk($sformatf("R5 seq%0d miss count", which), misses, (which == 1) ? 6 : 5);
   endtask

   task automatic t_fill();
      logic [7:0] rd; logic h; int w;
      do_reset();
      for (int i = 0; i < 4; i++) begin
         acc(0, 0, 4 * i, 8'h00, rd, h, w);
         chk($sformatf("R2 cold miss %0d", i), int'(h), 0);
         chk($sformatf("R10 miss stalls %0d", i), int'(w > 0), 1);
      end
      for (int i = 3; i >= 0; i--) begin
         acc(0, 0, 4 * i + 1, 8'h00, rd, h, w);
         chk($sformatf("R4 all resident hit %0d", i), int'(h), 1);
         chk($sformatf("R3 hit same cycle %0d", i), w, 0);
         chk($sformatf("R1 offset byte %0d", i), int'(rd), int'(pat(4 * i + 1)));
      end
      chk("R4 no eviction reads", m0_nrd, 4);
      chk("R4 no eviction writes", m0_nwr, 0);
   endtask

   task automatic t_wb();
      logic [7:0] rd; logic h; int w;
      do_reset();
      acc(0, 1, 1, 8'h3C, rd, h, w);
      chk("R8 write miss reported", int'(h), 0);
      chk("R8 write miss fetched", m0_nrd, 1);
      chk("R6 no memory write", m0_nwr, 0);
      chk("R6 memory byte stale", int'(m0.bytes_q[1]), int'(pat(1)));
      acc(0, 1, 2, 8'hC3, rd, h, w);
      chk("R6 write hit", int'(h), 1);
      chk("R3 write-back hit same cycle", w, 0);
      chk("R6 still no memory write", m0_nwr, 0);
      acc(0, 0, 1, 8'h00, rd, h, w);
      chk("R8 read after alloc hit", int'(h), 1);
      chk("R8 read after alloc data", int'(rd), 8'h3C);
      for (int i = 1; i < 4; i++) acc(0, 0, 4 * i, 8'h00, rd, h, w);
      acc(0, 0, 16, 8'h00, rd, h, w);
      chk("R11 evicting miss flag", int'(h), 0);
      chk("R6 evict data", int'(rd), int'(pat(16)));
      chk("R6 one write-back", m0_nwr, 1);
      chk("R6 full block be", int'(m0_lbe), 4'hF);
      chk("R6 byte1 written", int'(m0.bytes_q[1]), 8'h3C);
      chk("R6 byte2 written", int'(m0.bytes_q[2]), 8'hC3);
      chk("R6 byte3 kept", int'(m0.bytes_q[3]), int'(pat(3)));
      acc(0, 0, 1, 8'h00, rd, h, w);
      chk("R5 evicted block misses", int'(h), 0);
      chk("R6 reload data", int'(rd), 8'h3C);
      chk("R6 clean victim no write", m0_nwr, 1);
   endtask

   task automatic t_wt_nwa();
      logic [7:0] rd; logic h; int w;
      do_reset();
      acc(1, 0, 8, 8'h00, rd, h, w);
      acc(1, 1, 9, 8'h77, rd, h, w);
      chk("R7 write hit flag", int'(h), 1);
      chk("R7 waits on memory", int'(w > 0), 1);
      chk("R7 one memory write", m1_nwr, 1);
      chk("R7 byte enable lane1", int'(m1_lbe), 4'b0010);
      chk("R7 memory byte", int'(m1.bytes_q[9]), 8'h77);
      chk("R7 neighbour byte kept", int'(m1.bytes_q[10]), int'(pat(10)));
      acc(1, 0, 9, 8'h00, rd, h, w);
      chk("R7 cache updated hit", int'(h), 1);
      chk("R7 cache updated data", int'(rd), 8'h77);
      acc(1, 1, 20, 8'h11, rd, h, w);
      chk("R9 write miss flag", int'(h), 0);
      chk("R9 no fetch", m1_nrd, 1);
      chk("R9 memory written", int'(m1.bytes_q[20]), 8'h11);
      chk("R9 byte enable lane0", int'(m1_lbe), 4'b0001);
      acc(1, 0, 20, 8'h00, rd, h, w);
      chk("R9 cache untouched miss", int'(h), 0);
      chk("R9 read data", int'(rd), 8'h11);
   endtask

   initial begin
      #1200000;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_seq(1);
      t_seq(2);
      t_fill();
      t_wb();
      t_wt_nwa();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule